// File: doc/BRIEF.md
# Three-Byte Conditional Far-Jump Sequencer

This block runs the execute phase of a three-byte conditional jump in an 8-bit processor whose program counter is 16 bits wide. When the fetch logic has decoded the first byte of such an instruction, it pulses `start` for one cycle. With that pulse it presents the condition code and the three status flags: accumulator zero, carry, and the Q output latch. The block then spends two execute cycles reading the two operand bytes through a byte-wide read port.

At the end of the second execute cycle the block writes the program counter once. If the condition holds, the new value is the 16-bit target made from the operand bytes, high byte first. If it does not hold, the new value points just past the operand bytes, so execution continues with the next instruction in sequence.

Before the final write, the program counter owner sees no change. The first operand byte waits in a holding register until the second one arrives. The program counter value on `pc_val` is expected to stay constant from `start` until `done`.

Top module: `far_jump_seq`

## Requirements
- R1: After reset, and while no instruction is in progress, `mem_rd`, `pc_we`, `done` and `taken` are all 0.
- R2: A `start` pulse accepted while idle gives execute cycle 1 on the next cycle, with `mem_rd`=1 and `mem_addr`=`pc_val`. The cycle after that is execute cycle 2, with `mem_rd`=1, `mem_addr`=`pc_val`+1 (modulo 2^16) and `done`=1. The block then returns to idle.
- R3: `cond_code[1:0]` selects the test: 0 is always true, 1 is `acc_zero`, 2 is `carry_flag`, 3 is `q_flag`. `cond_code[2]`=1 inverts the test, so code 4 never jumps, 5 tests accumulator nonzero, 6 tests carry clear and 7 tests Q clear. `taken` in execute cycle 2 equals the result of this test.
- R4: When the test holds, `pc_next` = {byte read in execute cycle 1, byte read in execute cycle 2}, so the high byte comes first.
- R5: When the test fails, including code 4, `pc_next` = `pc_val`+2 modulo 2^16.
- R6: `pc_we` is 1 for exactly one cycle per instruction, in execute cycle 2, together with `done`. It is never 1 in execute cycle 1.
- R7: A `start` pulse that arrives during execute cycle 1 or execute cycle 2 is ignored. No extra read cycle and no extra write cycle follow.
- R8: The condition code and the flags are sampled in the `start` cycle. Changes on those inputs during the execute cycles have no effect on `taken` or `pc_next`.
- R9: Address arithmetic wraps modulo 2^16. With `pc_val`=FFFF, the second read goes to 0000 and a skip yields 0001. With `pc_val`=FFFE, a skip yields 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: a far-jump opcode has been decoded |
| cond_code | input | 3 | Test select in [1:0], invert in [2] |
| acc_zero | input | 1 | Accumulator-is-zero flag |
| carry_flag | input | 1 | Carry flag |
| q_flag | input | 1 | Q output latch state |
| pc_val | input | 16 | Current program counter, pointing at the first operand byte |
| mem_rd | output | 1 | Operand read strobe |
| mem_addr | output | 16 | Operand read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| pc_we | output | 1 | Program counter write strobe |
| pc_next | output | 16 | New program counter value, valid with `pc_we` |
| taken | output | 1 | The condition held (valid with `pc_we`) |
| done | output | 1 | Last execute cycle of the instruction |

## Verification
The two events that can meet in one cycle are the final program counter write in execute cycle 2 and a fresh `start` pulse. A second meeting is a flag change landing on an execute cycle, while the block is still using the flags it sampled. The bench drives `start` again during execute cycle 1 or execute cycle 2 of selected instructions, and flips every flag after the `start` cycle. It judges the outcome at the ports. Exactly one read pair and one write must appear, the cycle after the write must be idle, and `taken` and `pc_next` must match the flags sampled with the original `start`.

// File: rtl/far_jump_pkg.sv
package far_jump_pkg;

  typedef enum logic [1:0] {
    FJ_IDLE = 2'd0,
    FJ_EX1  = 2'd1,
    FJ_EX2  = 2'd2
  } fj_state_e;

  localparam logic [1:0] TEST_ALWAYS = 2'd0;
  localparam logic [1:0] TEST_ACCZ   = 2'd1;
  localparam logic [1:0] TEST_CARRY  = 2'd2;
  localparam logic [1:0] TEST_QLAT   = 2'd3;

  // Test selected by code[1:0]; code[2] flips the outcome.
  function automatic logic fj_cond_met(input logic [2:0] code,
                                       input logic az, input logic cy,
                                       input logic ql);
    logic base;
    unique case (code[1:0])
      TEST_ALWAYS: base = 1'b1;
      TEST_ACCZ:   base = az;
      TEST_CARRY:  base = cy;
      default:     base = ql;
    endcase
    return base ^ code[2];
  endfunction

endpackage

// File: rtl/far_jump_fsm.sv
module far_jump_fsm
  import far_jump_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic capture,
  output logic ex1,
  output logic ex2
);

  fj_state_e state_q, state_d;

  assign capture = start && (state_q == FJ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FJ_IDLE: if (start) state_d = FJ_EX1;
      FJ_EX1:  state_d = FJ_EX2;
      FJ_EX2:  state_d = FJ_IDLE;
      default: state_d = FJ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FJ_IDLE;
    else        state_q <= state_d;
  end

  assign ex1 = (state_q == FJ_EX1);
  assign ex2 = (state_q == FJ_EX2);

  AST_START_OPENS_EX1: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ex1 && !ex2);                                   // R2
  AST_EX1_THEN_EX2: assert property (@(posedge clk) disable iff (!rst_n)
    ex1 |=> ex2 && !ex1);                                       // R2
  AST_EX2_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ex2 |=> !ex1 && !ex2);                                      // R7

endmodule

// File: rtl/far_jump_cond.sv
module far_jump_cond
  import far_jump_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [2:0] code,
  input  logic       az,
  input  logic       cy,
  input  logic       ql,
  output logic       met_q
);

  logic met_now;

  assign met_now = fj_cond_met(code, az, cy, ql);

  always_ff @(posedge clk) begin
    if (!rst_n)       met_q <= 1'b0;
    else if (capture) met_q <= met_now;
  end

  AST_COND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(met_q));                               // R8
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && code == 3'd4) |=> !met_q);                      // R3

endmodule

// File: rtl/far_jump_addr.sv
module far_jump_addr #(
  parameter int DATA_W = 8,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex1,
  input  logic              ex2,
  input  logic              met,
  input  logic [PC_W-1:0]   pc_val,
  input  logic [DATA_W-1:0] rdata,
  output logic [PC_W-1:0]   rd_addr,
  output logic [PC_W-1:0]   pc_next
);

  // Step an address forward, wrapping at the counter width.
  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] base,
                                              input logic [1:0] amount);
    return base + PC_W'(amount);
  endfunction

  logic [DATA_W-1:0] hi_q;
  logic [PC_W-1:0]   target;
  logic [PC_W-1:0]   skip_pc;

  always_ff @(posedge clk) begin
    if (!rst_n)   hi_q <= '0;
    else if (ex1) hi_q <= rdata;
  end

  assign rd_addr = ex2 ? pc_step(pc_val, 2'd1) : pc_val;
  assign target  = {hi_q, rdata};
  assign skip_pc = pc_step(pc_val, 2'd2);
  assign pc_next = met ? target : skip_pc;

  AST_TARGET_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ex2 && met) |-> pc_next[PC_W-1:DATA_W] == $past(rdata));   // R4
  AST_SKIP_PAST_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex2 && !met) |-> pc_next == PC_W'(rd_addr + PC_W'(1)));    // R5
  AST_SECOND_ADDR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    ex2 |-> rd_addr == PC_W'($past(rd_addr) + PC_W'(1)));       // R9

endmodule

// File: rtl/far_jump_seq.sv
module far_jump_seq #(
  parameter int DATA_W = 8,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cond_code,
  input  logic              acc_zero,
  input  logic              carry_flag,
  input  logic              q_flag,
  input  logic [PC_W-1:0]   pc_val,
  output logic              mem_rd,
  output logic [PC_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pc_we,
  output logic [PC_W-1:0]   pc_next,
  output logic              taken,
  output logic              done
);

  logic capture;
  logic ex1;
  logic ex2;
  logic met_q;

  far_jump_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .capture (capture),
    .ex1     (ex1),
    .ex2     (ex2)
  );

  far_jump_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .code    (cond_code),
    .az      (acc_zero),
    .cy      (carry_flag),
    .ql      (q_flag),
    .met_q   (met_q)
  );

  far_jump_addr #(.DATA_W(DATA_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ex1     (ex1),
    .ex2     (ex2),
    .met     (met_q),
    .pc_val  (pc_val),
    .rdata   (mem_rdata),
    .rd_addr (mem_addr),
    .pc_next (pc_next)
  );

  assign mem_rd = ex1 | ex2;
  assign pc_we  = ex2;
  assign done   = ex2;
  assign taken  = ex2 & met_q;

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> $past(mem_rd) && !$past(pc_we));                  // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |-> !pc_we && !done && !taken);                     // R1
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && start) |=> !mem_rd);                              // R7

endmodule

// File: tb/far_jump_seq_tb.sv
module far_jump_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cond_code = '0;
  logic        acc_zero = 1'b0, carry_flag = 1'b0, q_flag = 1'b0;
  logic [15:0] pc_val = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        pc_we;
  logic [15:0] pc_next;
  logic        taken;
  logic        done;

  logic [15:0] pc_b = '0;
  logic [7:0]  hi_b = '0, lo_b = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // Memory model: operand bytes at pc and pc+1, filler elsewhere.
  assign mem_rdata = !mem_rd ? 8'h00 :
                     (mem_addr == pc_b) ? hi_b :
                     (mem_addr == 16'(pc_b + 16'd1)) ? lo_b : 8'hEE;

  far_jump_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_code(cond_code),
    .acc_zero(acc_zero), .carry_flag(carry_flag), .q_flag(q_flag),
    .pc_val(pc_val), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_next(pc_next),
    .taken(taken), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expect_jump(input logic [2:0] c, input logic az,
                                       input logic cy, input logic ql);
    case (c)
      3'd0: return 1'b1;
      3'd4: return 1'b0;
      3'd1: return az;
      3'd5: return !az;
      3'd2: return cy;
      3'd6: return !cy;
      3'd3: return ql;
      default: return !ql;
    endcase
  endfunction

  // One instruction; busy_sel: 0 none, 1 start in ex1, 2 start in ex2.
  task automatic run_instr(input logic [15:0] pc, input logic [2:0] c,
                           input logic [2:0] fl, input logic [7:0] hi,
                           input logic [7:0] lo, input bit scramble,
                           input int busy_sel);
    logic jmp;
    logic [15:0] exp_next;
    jmp = expect_jump(c, fl[0], fl[1], fl[2]);
    exp_next = jmp ? {hi, lo} : pc + 16'd2;
    @(negedge clk);
    pc_b = pc; hi_b = hi; lo_b = lo; pc_val = pc;
    cond_code = c; acc_zero = fl[0]; carry_flag = fl[1]; q_flag = fl[2];
    start = 1'b1;
    @(posedge clk); #1;
    chk("R2 ex1 read", {31'd0, mem_rd}, 32'd1);
    chk("R2 ex1 addr", {16'd0, mem_addr}, {16'd0, pc});
    chk("R6 no write in ex1", {30'd0, pc_we, done}, 32'd0);
    @(negedge clk);
    start = (busy_sel == 1);
    if (scramble) begin
      cond_code = ~c; acc_zero = ~fl[0]; carry_flag = ~fl[1]; q_flag = ~fl[2];
    end
    @(posedge clk); #1;
    chk("R2 ex2 done", {31'd0, done}, 32'd1);
    chk("R6 write in ex2", {31'd0, pc_we}, 32'd1);
    chk("R9 ex2 addr", {16'd0, mem_addr}, {16'd0, 16'(pc + 16'd1)});
    chk(scramble ? "R8 taken frozen" : "R3 taken", {31'd0, taken}, {31'd0, jmp});
    chk(jmp ? "R4 target" : "R5 skip", {16'd0, pc_next}, {16'd0, exp_next});
    @(negedge clk);
    start = (busy_sel == 2);
    @(posedge clk); #1;
    chk("R7 idle after", {29'd0, mem_rd, pc_we, done}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    chk("R1 quiet", {28'd0, mem_rd, pc_we, done, taken}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {28'd0, mem_rd, pc_we, done, taken}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle after reset", {28'd0, mem_rd, pc_we, done, taken}, 32'd0);
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 8; f++) begin
        run_instr(16'((c * 8 + f) * 1013 + 256), 3'(c), 3'(f),
                  8'(c * 37 + f), 8'(f * 29 + c + 1), f[0], (c + f) % 3);
      end
    end
    run_instr(16'hFFFF, 3'd4, 3'd0, 8'h12, 8'h34, 1'b0, 0);   // R9 skip -> 0001
    run_instr(16'hFFFE, 3'd5, 3'd1, 8'h56, 8'h78, 1'b0, 2);   // R9 skip -> 0000
    run_instr(16'hFFFF, 3'd0, 3'd0, 8'hAB, 8'hCD, 1'b1, 1);   // R9 taken
    run_instr(16'h0000, 3'd0, 3'd0, 8'hFF, 8'hFF, 1'b0, 0);   // R4 to FFFF
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule